// File: doc/BRIEF.md
# Software-Managed Variable-Page Translation Buffer

This block is a fully associative translation buffer that turns a 40-bit virtual address into a 32-bit physical address. The virtual address is the 32-bit effective address of the access together with an 8-bit process identifier. Each of the 16 entries carries its own page size, from 1KB up to 16MB in steps of four. The page size decides how many effective-address bits take part in the compare. It also decides how many low address bits pass straight through to the physical address.

The hardware never walks a page table and never picks a victim. Software loads, reads back and clears entries through a single operation port. A lookup either returns a hit with the physical address, the entry index and the write/execute permissions, or it returns a miss. The miss is only a flag; the surrounding logic reacts to it.

Lookups are registered. A request presented in one cycle is answered in the next. The answer reflects the table as it stood in the request cycle.

Top module: `vpage_tlb`

## Requirements
- R1: After reset every entry is invalid: rsp_valid and rd_ack are 0, any lookup misses, and a read returns rd_vld = 0.
- R2: A lookup requested with lk_req in cycle n is answered with rsp_valid = 1 in cycle n+1, using the table contents of cycle n; a software write in cycle n is not seen by that lookup. Without lk_req, rsp_valid is 0 in the next cycle.
- R3: An entry matches when it is valid, its tag identifier equals lk_pid or is zero (global), and the effective-address bits above the entry's page offset equal the corresponding page-number bits. Page-number bit j stands for effective-address bit j+10.
- R4: On a hit, the physical address is made of two parts. The stored real page-number bits above the page offset form the high part. The effective-address bits below the page offset form the low part. Stored page-number bits inside the offset are ignored.
- R5: The 3-bit size code s selects a page of 1KB·4^s, so the page offset is 10+2s bits: 0=1KB, 1=4KB, 2=16KB, 3=64KB, 4=256KB, 5=1MB, 6=4MB, 7=16MB.
- R6: sw_op = 01 (write) stores sw_vld and the entry fields at index sw_idx; a lookup in the following cycle sees the new entry.
- R7: sw_op = 10 (read) returns the fields of entry sw_idx on the rd_* outputs with rd_ack = 1 in the next cycle; rd_ack is 0 in the cycle after any other operation.
- R8: sw_op = 11 (invalidate all) clears every valid bit in one cycle; a lookup in the next cycle misses.
- R9: When several entries match, the lowest index wins and rsp_multi is 1; with a single match rsp_multi is 0.
- R10: On a hit, rsp_wr and rsp_ex carry the permission bits of the selected entry.
- R11: On a miss, rsp_hit, rsp_multi, rsp_wr, rsp_ex, rsp_idx and rsp_pa are all 0.
- R12: sw_op = 00 changes no entry, whatever sw_idx and the data inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address to translate |
| lk_pid | input | 8 | Process identifier of the lookup |
| rsp_valid | output | 1 | Lookup answer valid (one cycle after lk_req) |
| rsp_hit | output | 1 | At least one entry matched |
| rsp_multi | output | 1 | More than one entry matched |
| rsp_idx | output | 4 | Index of the selected entry |
| rsp_pa | output | 32 | Translated physical address |
| rsp_wr | output | 1 | Write permission of the selected entry |
| rsp_ex | output | 1 | Execute permission of the selected entry |
| sw_op | input | 2 | Software operation: 00 none, 01 write, 10 read, 11 invalidate all |
| sw_idx | input | 4 | Entry index for write and read |
| sw_vld | input | 1 | Valid bit to write |
| sw_size | input | 3 | Page size code to write |
| sw_epn | input | 22 | Effective page number to write (EA bits 31..10) |
| sw_tid | input | 8 | Tag identifier to write (0 = global) |
| sw_rpn | input | 22 | Real page number to write (PA bits 31..10) |
| sw_wr | input | 1 | Write permission to write |
| sw_ex | input | 1 | Execute permission to write |
| rd_ack | output | 1 | Read data valid |
| rd_vld | output | 1 | Read-back valid bit |
| rd_size | output | 3 | Read-back size code |
| rd_epn | output | 22 | Read-back effective page number |
| rd_tid | output | 8 | Read-back tag identifier |
| rd_rpn | output | 22 | Read-back real page number |
| rd_wr | output | 1 | Read-back write permission |
| rd_ex | output | 1 | Read-back execute permission |

## Verification
A software write and a lookup can fall in the same cycle. The case of interest is one that invalidates an entry the lookup is about to match. The bench drives both in one cycle, clearing the lower-index entry of a doubly mapped page. It expects the old answer: index 9 with the multi-hit flag. It then issues a second lookup to the same address and expects the higher-index entry alone, with its own physical address and the flag clear. The same ordering is asserted for invalidate-all: a lookup issued in the cycle after that operation must miss.

// File: rtl/vpt_pkg.sv
package vpt_pkg;

  localparam int unsigned EA_W    = 32;
  localparam int unsigned PID_W   = 8;
  localparam int unsigned PA_W    = 32;
  localparam int unsigned MIN_OFS = 10;
  localparam int unsigned SZ_W    = 3;
  localparam int unsigned SZ_STEP = 2;

  localparam int unsigned EPN_W = EA_W - MIN_OFS;
  localparam int unsigned RPN_W = PA_W - MIN_OFS;

  typedef enum logic [1:0] {
    OP_NONE  = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_INVAL = 2'b11
  } sw_op_e;

  typedef struct packed {
    logic [SZ_W-1:0]  size;
    logic [EPN_W-1:0] epn;
    logic [PID_W-1:0] tid;
    logic [RPN_W-1:0] rpn;
    logic             wr;
    logic             ex;
  } tlb_body_t;

  typedef struct packed {
    logic      vld;
    tlb_body_t body;
  } tlb_entry_t;

  // Bit j set: page-number bit j lies above the page offset for size code sz.
  function automatic logic [EPN_W-1:0] epn_mask(input logic [SZ_W-1:0] sz);
    logic [EPN_W-1:0] m;
    for (int j = 0; j < int'(EPN_W); j++) begin
      m[j] = (j >= int'(SZ_STEP) * int'(sz));
    end
    return m;
  endfunction

  function automatic logic [RPN_W-1:0] rpn_mask(input logic [SZ_W-1:0] sz);
    logic [RPN_W-1:0] m;
    for (int j = 0; j < int'(RPN_W); j++) begin
      m[j] = (j >= int'(SZ_STEP) * int'(sz));
    end
    return m;
  endfunction

endpackage

// File: rtl/vpt_entry_store.sv
module vpt_entry_store
  import vpt_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  sw_op_e           op_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             wvld_i,
  input  tlb_body_t        wbody_i,
  output tlb_entry_t       ent_o [N_ENT],
  output logic             rd_ack_o,
  output tlb_entry_t       rd_ent_o
);

  logic [N_ENT-1:0] vld_q, vld_d;
  tlb_body_t        body_q [N_ENT];
  logic             rd_ack_d, rd_ack_q;
  logic             rd_en;
  tlb_entry_t       rd_q;

  // valid bits: next state
  always_comb begin
    vld_d = vld_q;
    unique case (op_i)
      OP_WRITE: vld_d[idx_i] = wvld_i;
      OP_INVAL: vld_d        = '0;
      default:  ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // entry bodies: one enabled register per entry, no reset
  for (genvar e = 0; e < int'(N_ENT); e++) begin : g_ent
    logic we;
    assign we = (op_i == OP_WRITE) && (idx_i == IDX_W'(e));

    always_ff @(posedge clk) begin
      if (we) begin
        body_q[e] <= wbody_i;
      end
    end

    assign ent_o[e] = '{vld: vld_q[e], body: body_q[e]};
  end

  // read port
  assign rd_en    = (op_i == OP_READ);
  assign rd_ack_d = rd_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ack_q <= 1'b0;
    end else begin
      rd_ack_q <= rd_ack_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_q <= ent_o[idx_i];
    end
  end

  assign rd_ack_o = rd_ack_q;
  assign rd_ent_o = rd_q;

endmodule

// File: rtl/vpt_match.sv
module vpt_match
  import vpt_pkg::*;
#(
  parameter int unsigned N_ENT = 16
) (
  input  tlb_entry_t       ent_i [N_ENT],
  input  logic [EA_W-1:0]  ea_i,
  input  logic [PID_W-1:0] pid_i,
  output logic [N_ENT-1:0] hit_vec_o
);

  logic [EPN_W-1:0] ea_page;
  assign ea_page = ea_i[EA_W-1:MIN_OFS];

  for (genvar e = 0; e < int'(N_ENT); e++) begin : g_cmp
    logic [EPN_W-1:0] cmp_mask;
    logic             tid_ok;
    logic             page_ok;

    assign cmp_mask = epn_mask(ent_i[e].body.size);
    assign tid_ok   = (ent_i[e].body.tid == pid_i) || (ent_i[e].body.tid == '0);
    assign page_ok  = ((ea_page ^ ent_i[e].body.epn) & cmp_mask) == '0;

    assign hit_vec_o[e] = ent_i[e].vld && tid_ok && page_ok;
  end

endmodule

// File: rtl/vpt_select.sv
module vpt_select
  import vpt_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  tlb_entry_t       ent_i [N_ENT],
  input  logic [N_ENT-1:0] hit_vec_i,
  input  logic [EA_W-1:0]  ea_i,
  output logic             hit_o,
  output logic             multi_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [PA_W-1:0]  pa_o,
  output logic             wr_o,
  output logic             ex_o
);

  logic [IDX_W-1:0] sel;
  tlb_body_t        sel_body;
  logic [RPN_W-1:0] keep_mask;
  logic [RPN_W-1:0] ea_hi;
  logic [RPN_W-1:0] pa_hi;

  // lowest set index wins: scan downward so the last assignment is the lowest
  always_comb begin
    sel = '0;
    for (int e = int'(N_ENT) - 1; e >= 0; e--) begin
      if (hit_vec_i[e]) begin
        sel = IDX_W'(e);
      end
    end
  end

  assign hit_o    = |hit_vec_i;
  assign multi_o  = (hit_vec_i & (hit_vec_i - 1'b1)) != '0;
  assign sel_body = ent_i[sel].body;

  assign keep_mask = rpn_mask(sel_body.size);
  assign ea_hi     = ea_i[MIN_OFS +: RPN_W];
  assign pa_hi     = (sel_body.rpn & keep_mask) | (ea_hi & ~keep_mask);

  always_comb begin
    if (hit_o) begin
      idx_o = sel;
      pa_o  = {pa_hi, ea_i[MIN_OFS-1:0]};
      wr_o  = sel_body.wr;
      ex_o  = sel_body.ex;
    end else begin
      idx_o = '0;
      pa_o  = '0;
      wr_o  = 1'b0;
      ex_o  = 1'b0;
    end
  end

endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
  import vpt_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [EA_W-1:0]  lk_ea,
  input  logic [PID_W-1:0] lk_pid,
  output logic             rsp_valid,
  output logic             rsp_hit,
  output logic             rsp_multi,
  output logic [IDX_W-1:0] rsp_idx,
  output logic [PA_W-1:0]  rsp_pa,
  output logic             rsp_wr,
  output logic             rsp_ex,
  input  logic [1:0]       sw_op,
  input  logic [IDX_W-1:0] sw_idx,
  input  logic             sw_vld,
  input  logic [SZ_W-1:0]  sw_size,
  input  logic [EPN_W-1:0] sw_epn,
  input  logic [PID_W-1:0] sw_tid,
  input  logic [RPN_W-1:0] sw_rpn,
  input  logic             sw_wr,
  input  logic             sw_ex,
  output logic             rd_ack,
  output logic             rd_vld,
  output logic [SZ_W-1:0]  rd_size,
  output logic [EPN_W-1:0] rd_epn,
  output logic [PID_W-1:0] rd_tid,
  output logic [RPN_W-1:0] rd_rpn,
  output logic             rd_wr,
  output logic             rd_ex
);

  sw_op_e           op;
  tlb_body_t        wbody;
  tlb_entry_t       ent [N_ENT];
  tlb_entry_t       rd_ent;
  logic [N_ENT-1:0] hit_vec;

  logic             c_hit, c_multi, c_wr, c_ex;
  logic [IDX_W-1:0] c_idx;
  logic [PA_W-1:0]  c_pa;

  logic             v_q, v_d;
  logic             hit_q, multi_q, wr_q, ex_q;
  logic [IDX_W-1:0] idx_q;
  logic [PA_W-1:0]  pa_q;

  assign op    = sw_op_e'(sw_op);
  assign wbody = '{size: sw_size, epn: sw_epn, tid: sw_tid,
                   rpn: sw_rpn, wr: sw_wr, ex: sw_ex};

  vpt_entry_store #(.N_ENT(N_ENT)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_i     (op),
    .idx_i    (sw_idx),
    .wvld_i   (sw_vld),
    .wbody_i  (wbody),
    .ent_o    (ent),
    .rd_ack_o (rd_ack),
    .rd_ent_o (rd_ent)
  );

  vpt_match #(.N_ENT(N_ENT)) u_match (
    .ent_i     (ent),
    .ea_i      (lk_ea),
    .pid_i     (lk_pid),
    .hit_vec_o (hit_vec)
  );

  vpt_select #(.N_ENT(N_ENT)) u_sel (
    .ent_i     (ent),
    .hit_vec_i (hit_vec),
    .ea_i      (lk_ea),
    .hit_o     (c_hit),
    .multi_o   (c_multi),
    .idx_o     (c_idx),
    .pa_o      (c_pa),
    .wr_o      (c_wr),
    .ex_o      (c_ex)
  );

  // response stage
  assign v_d = lk_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q     <= 1'b0;
      hit_q   <= 1'b0;
      multi_q <= 1'b0;
      wr_q    <= 1'b0;
      ex_q    <= 1'b0;
    end else begin
      v_q <= v_d;
      if (lk_req) begin
        hit_q   <= c_hit;
        multi_q <= c_multi;
        wr_q    <= c_wr;
        ex_q    <= c_ex;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (lk_req) begin
      idx_q <= c_idx;
      pa_q  <= c_pa;
    end
  end

  assign rsp_valid = v_q;
  assign rsp_hit   = hit_q;
  assign rsp_multi = multi_q;
  assign rsp_idx   = idx_q;
  assign rsp_pa    = pa_q;
  assign rsp_wr    = wr_q;
  assign rsp_ex    = ex_q;

  assign rd_vld  = rd_ent.vld;
  assign rd_size = rd_ent.body.size;
  assign rd_epn  = rd_ent.body.epn;
  assign rd_tid  = rd_ent.body.tid;
  assign rd_rpn  = rd_ent.body.rpn;
  assign rd_wr   = rd_ent.body.wr;
  assign rd_ex   = rd_ent.body.ex;

endmodule

// File: rtl/vpage_tlb_checker.sv
module vpage_tlb_checker
  import vpt_pkg::*;
#(
  parameter int unsigned N_ENT = 16,
  localparam int unsigned IDX_W = $clog2(N_ENT)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             lk_req,
  input logic [EA_W-1:0]  lk_ea,
  input logic [1:0]       sw_op,
  input logic             rsp_valid,
  input logic             rsp_hit,
  input logic             rsp_multi,
  input logic [IDX_W-1:0] rsp_idx,
  input logic [PA_W-1:0]  rsp_pa,
  input logic             rsp_wr,
  input logic             rsp_ex,
  input logic             rd_ack
);

  // R2: answer exactly one cycle after a request
  a_r2_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid);

  a_r2_no_unrequested_resp: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> !rsp_valid);

  // R4: offset bits below the smallest page always come from the effective address
  a_r4_offset_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_hit) |-> (rsp_pa[MIN_OFS-1:0] == $past(lk_ea[MIN_OFS-1:0])));

  // R7: read data acknowledged in the following cycle only
  a_r7_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_op == OP_READ) |=> rd_ack);

  a_r7_no_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_op != OP_READ) |=> !rd_ack);

  // R8: a lookup issued right after invalidate-all misses
  a_r8_inval_then_miss: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sw_op) == OP_INVAL && lk_req) |=> !rsp_hit);

  // R9: multi-hit only with a hit
  a_r9_multi_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_multi) |-> rsp_hit);

  // R11: a miss carries no payload
  a_r11_miss_is_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |->
      (rsp_pa == '0 && rsp_idx == '0 && !rsp_wr && !rsp_ex && !rsp_multi));

endmodule

bind vpage_tlb vpage_tlb_checker #(.N_ENT(N_ENT)) i_chk (.*);

// File: tb/test_vpage_tlb.sv
`timescale 1ns/1ps
module test_vpage_tlb;

  logic        clk;
  logic        rst_n;
  logic        lk_req;
  logic [31:0] lk_ea;
  logic [7:0]  lk_pid;
  logic        rsp_valid, rsp_hit, rsp_multi, rsp_wr, rsp_ex;
  logic [3:0]  rsp_idx;
  logic [31:0] rsp_pa;
  logic [1:0]  sw_op;
  logic [3:0]  sw_idx;
  logic        sw_vld, sw_wr, sw_ex;
  logic [2:0]  sw_size;
  logic [21:0] sw_epn, sw_rpn;
  logic [7:0]  sw_tid;
  logic        rd_ack, rd_vld, rd_wr, rd_ex;
  logic [2:0]  rd_size;
  logic [21:0] rd_epn, rd_rpn;
  logic [7:0]  rd_tid;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  vpage_tlb i_vpage_tlb (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic sw_write(input logic [3:0] idx, input logic vld, input logic [2:0] size,
                          input logic [31:0] ea_base, input logic [7:0] tid,
                          input logic [31:0] pa_base, input logic wr, input logic ex);
    sw_op = 2'b01; sw_idx = idx; sw_vld = vld; sw_size = size;
    sw_epn = ea_base[31:10]; sw_tid = tid; sw_rpn = pa_base[31:10];
    sw_wr = wr; sw_ex = ex;
    @(negedge clk);
    sw_op = 2'b00;
  endtask

  task automatic lookup(input logic [31:0] ea, input logic [7:0] pid);
    lk_req = 1'b1; lk_ea = ea; lk_pid = pid;
    @(negedge clk);
    lk_req = 1'b0;
  endtask

  task automatic chk_rsp(input string req, input logic hit, input logic [3:0] idx,
                         input logic [31:0] pa, input logic multi,
                         input logic wr, input logic ex);
    chk({req, " valid"}, 64'(rsp_valid), 64'(1'b1));
    chk({req, " hit"},   64'(rsp_hit),   64'(hit));
    chk({req, " idx"},   64'(rsp_idx),   64'(idx));
    chk({req, " pa"},    64'(rsp_pa),    64'(pa));
    chk({req, " multi"}, 64'(rsp_multi), 64'(multi));
    chk({req, " wr"},    64'(rsp_wr),    64'(wr));
    chk({req, " ex"},    64'(rsp_ex),    64'(ex));
  endtask

  task automatic sw_read(input logic [3:0] idx);
    sw_op = 2'b10; sw_idx = idx;
    @(negedge clk);
    sw_op = 2'b00;
  endtask

  // R1: reset state
  task automatic t_reset();
    chk("R1 rsp_valid", 64'(rsp_valid), 64'd0);
    chk("R1 rd_ack", 64'(rd_ack), 64'd0);
    lookup(32'h0000_0000, 8'h00);
    chk_rsp("R1 empty lookup", 1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    chk("R2 no request no answer", 64'(rsp_valid), 64'd0);
    sw_read(4'd5);
    chk("R1 read ack", 64'(rd_ack), 64'd1);
    chk("R1 read valid", 64'(rd_vld), 64'd0);
  endtask

  // R3 R4 R5 R6 R10: 4KB page with a private tag
  task automatic t_page_4k();
    sw_write(4'd2, 1'b1, 3'd1, 32'h1234_5000, 8'h21, 32'h0007_3000, 1'b1, 1'b0);
    lookup(32'h1234_5ABC, 8'h21);
    chk_rsp("R6 R4 4KB hit", 1'b1, 4'd2, 32'h0007_3ABC, 1'b0, 1'b1, 1'b0);
    lookup(32'h1234_6ABC, 8'h21);
    chk_rsp("R3 R11 next page", 1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0);
    lookup(32'h1234_5ABC, 8'h22);
    chk_rsp("R3 tag mismatch", 1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask

  // R3 R5: 1KB global page
  task automatic t_global_1k();
    sw_write(4'd3, 1'b1, 3'd0, 32'h8000_0400, 8'h00, 32'h0010_0000, 1'b0, 1'b0);
    lookup(32'h8000_07FF, 8'h99);
    chk_rsp("R3 global 1KB", 1'b1, 4'd3, 32'h0010_03FF, 1'b0, 1'b0, 1'b0);
    lookup(32'h8000_0800, 8'h99);
    chk_rsp("R5 1KB bound", 1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask

  // R4 R5 R10: 16MB page, stored low page bits are junk and must be ignored
  task automatic t_page_16m();
    sw_op = 2'b01; sw_idx = 4'd7; sw_vld = 1'b1; sw_size = 3'd7;
    sw_epn = 22'h028000 | 22'h003FFF; sw_tid = 8'h21;
    sw_rpn = 22'h3C4000 | 22'h001555; sw_wr = 1'b0; sw_ex = 1'b1;
    @(negedge clk);
    sw_op = 2'b00;
    lookup(32'h0AFE_DCBA, 8'h21);
    chk_rsp("R4 R5 R10 16MB hit", 1'b1, 4'd7, 32'hF1FE_DCBA, 1'b0, 1'b0, 1'b1);
    lookup(32'h0B00_0000, 8'h21);
    chk_rsp("R5 16MB bound", 1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask

  // R9: overlapping entries
  task automatic t_multi();
    sw_write(4'd12, 1'b1, 3'd2, 32'h4000_0000, 8'h00, 32'h0020_0000, 1'b1, 1'b1);
    sw_write(4'd9,  1'b1, 3'd1, 32'h4000_0000, 8'h00, 32'h0030_0000, 1'b0, 1'b1);
    lookup(32'h4000_0123, 8'h05);
    chk_rsp("R9 lowest wins", 1'b1, 4'd9, 32'h0030_0123, 1'b1, 1'b0, 1'b1);
    lookup(32'h4000_2123, 8'h05);
    chk_rsp("R9 single match", 1'b1, 4'd12, 32'h0020_2123, 1'b0, 1'b1, 1'b1);
  endtask

  // R2 R6: write and lookup in the same cycle
  task automatic t_same_cycle();
    sw_op = 2'b01; sw_idx = 4'd9; sw_vld = 1'b0; sw_size = 3'd1;
    sw_epn = 22'h100000; sw_tid = 8'h00; sw_rpn = 22'h0; sw_wr = 1'b0; sw_ex = 1'b0;
    lk_req = 1'b1; lk_ea = 32'h4000_0123; lk_pid = 8'h05;
    @(negedge clk);
    sw_op = 2'b00; lk_req = 1'b0;
    chk_rsp("R2 old table seen", 1'b1, 4'd9, 32'h0030_0123, 1'b1, 1'b0, 1'b1);
    lookup(32'h4000_0123, 8'h05);
    chk_rsp("R6 write visible", 1'b1, 4'd12, 32'h0020_0123, 1'b0, 1'b1, 1'b1);
  endtask

  // R7: read back
  task automatic t_read();
    sw_read(4'd7);
    chk("R7 ack", 64'(rd_ack), 64'd1);
    chk("R7 vld", 64'(rd_vld), 64'd1);
    chk("R7 size", 64'(rd_size), 64'd7);
    chk("R7 epn", 64'(rd_epn), 64'h02BFFF);
    chk("R7 tid", 64'(rd_tid), 64'h21);
    chk("R7 rpn", 64'(rd_rpn), 64'h3C5555);
    chk("R7 perms", 64'({rd_wr, rd_ex}), 64'b01);
    @(negedge clk);
    chk("R7 ack drops", 64'(rd_ack), 64'd0);
  endtask

  // R12: idle op with busy data lines
  task automatic t_nop();
    sw_op = 2'b00; sw_idx = 4'd2; sw_vld = 1'b0; sw_size = 3'd6;
    sw_epn = 22'h3FFFFF; sw_tid = 8'hFF; sw_rpn = 22'h3FFFFF; sw_wr = 1'b0; sw_ex = 1'b1;
    @(negedge clk);
    lookup(32'h1234_5ABC, 8'h21);
    chk_rsp("R12 entry intact", 1'b1, 4'd2, 32'h0007_3ABC, 1'b0, 1'b1, 1'b0);
    sw_read(4'd2);
    chk("R12 epn intact", 64'(rd_epn), 64'(22'h048D14));
    chk("R12 size intact", 64'(rd_size), 64'd1);
  endtask

  // R6: write an invalid entry
  task automatic t_write_invalid();
    sw_write(4'd2, 1'b0, 3'd1, 32'h1234_5000, 8'h21, 32'h0007_3000, 1'b1, 1'b0);
    lookup(32'h1234_5ABC, 8'h21);
    chk_rsp("R6 cleared entry misses", 1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0);
  endtask

  // R8: invalidate all
  task automatic t_inval();
    sw_op = 2'b11;
    @(negedge clk);
    sw_op = 2'b00;
    lookup(32'h0AFE_DCBA, 8'h21);
    chk_rsp("R8 16MB gone", 1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0);
    lookup(32'h4000_2123, 8'h05);
    chk_rsp("R8 16KB gone", 1'b0, 4'd0, 32'h0, 1'b0, 1'b0, 1'b0);
    sw_read(4'd7);
    chk("R8 read valid", 64'(rd_vld), 64'd0);
  endtask

  initial begin
    rst_n = 1'b0; lk_req = 1'b0; lk_ea = '0; lk_pid = '0;
    sw_op = 2'b00; sw_idx = '0; sw_vld = 1'b0; sw_size = '0;
    sw_epn = '0; sw_tid = '0; sw_rpn = '0; sw_wr = 1'b0; sw_ex = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page_4k();
    t_global_1k();
    t_page_16m();
    t_multi();
    t_same_cycle();
    t_read();
    t_nop();
    t_write_invalid();
    t_inval();
    @(negedge clk);
    finish_run();
  end

  initial begin
    #(4 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

endmodule